// File: doc/BRIEF.md
# Load/Store Address and Data Formatting Unit

This block sits in the execution stage of a 64-bit integer pipeline that has 32 registers, and it prepares every memory access. It takes one decoded operation at a time. Each operation carries a base register value, a signed 16-bit displacement, a register number and the value of that register. The block forms the effective address and decides whether the access goes ahead, traps or is skipped. For a store it places the data and byte enables into the correct lanes of a 64-bit bus. For a load it extracts and extends the returned data for writeback. Two operations compute an address only and never touch memory.

The block also holds one load-locked reservation. Locked loads set it and conditional stores consume it. A conditional store writes its success flag back into its own source register. The memory side is a plain valid/ready request port with a separate response strobe. The block keeps one operation in flight and raises `op_done` when that operation ends, whether it ends in writeback, a store, a trap or a skipped load.

Operation codes (`op_code`): 0 address, 1 address-high, 2 load byte, 3 load half, 4 load word, 5 load doubleword, 6 load doubleword unaligned, 7 load word locked, 8 load doubleword locked, 9 store byte, 10 store half, 11 store word, 12 store doubleword, 13 store doubleword unaligned, 14 store word conditional, 15 store doubleword conditional.

Top module: `lsu_front`

## Requirements
- R1: The effective address is `base_val` plus `disp_val` sign-extended to 64 bits, and it appears on `req_addr` for every access that is performed.
- R2: Code 0 writes base plus displacement, and code 1 writes base plus the sign-extended displacement shifted left by 16, to `wb_reg` one cycle after acceptance, with no memory request.
- R3: The load data lane starts at byte `req_addr[2:0]` of `rsp_rdata`. Byte and half loads zero-extend, word loads sign-extend from bit 31, and doubleword loads return all 64 bits. Writeback happens one cycle after `rsp_valid`.
- R4: `req_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A store places its low bytes at lane `req_addr[2:0]` of `req_wdata`, and `req_be` marks exactly those bytes.
- R5: A non-locked load whose `reg_sel` is 31 issues no request and raises no trap, even when its address is misaligned. It only pulses `op_done`.
- R6: Locked loads always issue their request and set the reservation, even when `reg_sel` is 31. `wb_valid` is never raised for register 31.
- R7: The unaligned doubleword variants (codes 6 and 13) clear address bits [2:0] and use size 3, so they never trap.
- R8: Any other access whose address is not a multiple of its size pulses `trap` with `trap_addr` equal to the effective address, with no request and no writeback.
- R9: A conditional store succeeds only if the reservation is valid and covers the same 8-byte-aligned quadword. On success it issues the store and writes 1 after the request is accepted. On failure it issues no request and writes 0. Every performed conditional store clears the reservation.
- R10: When a store's `reg_sel` is 31, the stored data is zero whatever `src_val` holds.
- R11: While `req_valid` is high and `req_ready` is low, the request and all its fields stay unchanged.
- R12: `op_ready` is low from acceptance until the cycle in which `op_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle and able to accept an operation |
| op_code | input | 5 | Operation code (see table above) |
| base_val | input | 64 | Base register value |
| disp_val | input | 16 | Signed displacement |
| reg_sel | input | 5 | Destination or source register number |
| src_val | input | 64 | Value of register `reg_sel` (store data) |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Request address |
| req_size | output | 2 | Access size code |
| req_write | output | 1 | 1 for a store |
| req_wdata | output | 64 | Lane-aligned store data |
| req_be | output | 8 | Byte enables |
| rsp_valid | input | 1 | Load data returned |
| rsp_rdata | input | 64 | The quadword that holds the load address |
| wb_valid | output | 1 | Writeback strobe |
| wb_reg | output | 5 | Writeback register |
| wb_data | output | 64 | Writeback value |
| trap | output | 1 | Alignment trap strobe |
| trap_addr | output | 64 | Faulting effective address |
| op_done | output | 1 | Operation finished |

## Verification
A corrupted reservation shows at the ports on the next conditional store, which then reports the wrong flag in the cycle after acceptance and either issues or drops its request. A wrong lane or size held in the latched request shows in the request fields while `req_valid` is high, or in the extended writeback one cycle after the response. The bench therefore checks the address, byte enables, data and writeback of every vector. A stuck sequencer shows as `op_done` never arriving, or as `op_ready` rising while a request is still pending.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int XLEN      = 64;
    localparam int DISPW     = 16;
    localparam int REGW      = 5;
    localparam int NBYTE     = XLEN / 8;
    localparam int LANEW     = $clog2(NBYTE);
    localparam logic [REGW-1:0] ZERO_REG = 5'd31;

    typedef enum logic [4:0] {
        OP_ADDR = 5'd0, OP_ADDR_HI = 5'd1,
        OP_LD_B = 5'd2, OP_LD_H = 5'd3, OP_LD_W = 5'd4, OP_LD_D = 5'd5,
        OP_LD_DU = 5'd6, OP_LD_WL = 5'd7, OP_LD_DL = 5'd8,
        OP_ST_B = 5'd9, OP_ST_H = 5'd10, OP_ST_W = 5'd11, OP_ST_D = 5'd12,
        OP_ST_DU = 5'd13, OP_ST_WC = 5'd14, OP_ST_DC = 5'd15
    } lsu_op_e;

    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;

    typedef struct packed {
        logic      addr_only;
        logic      hi_disp;
        logic      is_write;
        logic      is_lock;
        logic      is_cond;
        logic      force_al;
        logic      sign_ext;
        acc_size_e size;
    } op_dec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} seq_e;

    function automatic op_dec_t decode_op(input logic [4:0] code);
        op_dec_t d;
        d = '0;
        d.size = SZ_D;
        case (code)
            OP_ADDR:    d.addr_only = 1'b1;
            OP_ADDR_HI: begin d.addr_only = 1'b1; d.hi_disp = 1'b1; end
            OP_LD_B:    d.size = SZ_B;
            OP_LD_H:    d.size = SZ_H;
            OP_LD_W:    begin d.size = SZ_W; d.sign_ext = 1'b1; end
            OP_LD_D:    d.size = SZ_D;
            OP_LD_DU:   d.force_al = 1'b1;
            OP_LD_WL:   begin d.size = SZ_W; d.sign_ext = 1'b1; d.is_lock = 1'b1; end
            OP_LD_DL:   d.is_lock = 1'b1;
            OP_ST_B:    begin d.size = SZ_B; d.is_write = 1'b1; end
            OP_ST_H:    begin d.size = SZ_H; d.is_write = 1'b1; end
            OP_ST_W:    begin d.size = SZ_W; d.is_write = 1'b1; end
            OP_ST_D:    d.is_write = 1'b1;
            OP_ST_DU:   begin d.is_write = 1'b1; d.force_al = 1'b1; end
            OP_ST_WC:   begin d.size = SZ_W; d.is_write = 1'b1; d.is_cond = 1'b1; end
            OP_ST_DC:   begin d.is_write = 1'b1; d.is_cond = 1'b1; end
            default:    d.addr_only = 1'b1;
        endcase
        return d;
    endfunction

    function automatic logic [LANEW-1:0] size_mask(input acc_size_e s);
        return LANEW'((1 << s) - 1);
    endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
(
    input  op_dec_t           dec,
    input  logic [XLEN-1:0]   base,
    input  logic [DISPW-1:0]  disp,
    output logic [XLEN-1:0]   ea,
    output logic [XLEN-1:0]   acc_addr,
    output acc_size_e         acc_size,
    output logic              misaligned
);
    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] offset;

    always_comb begin
        disp_ext   = {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
        offset     = dec.hi_disp ? (disp_ext << 16) : disp_ext;
        ea         = base + offset;
        acc_size   = dec.force_al ? SZ_D : dec.size;
        acc_addr   = dec.force_al ? {ea[XLEN-1:LANEW], {LANEW{1'b0}}} : ea;
        misaligned = !dec.force_al && ((ea[LANEW-1:0] & size_mask(dec.size)) != '0);
    end
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0]  data,
    input  logic [LANEW-1:0] lane,
    input  acc_size_e        size,
    output logic [XLEN-1:0]  wdata,
    output logic [NBYTE-1:0] be
);
    logic [XLEN-1:0]  trimmed;
    logic [NBYTE-1:0] base_be;

    always_comb begin
        case (size)
            SZ_B:    begin trimmed = {{(XLEN-8){1'b0}},  data[7:0]};  base_be = NBYTE'(8'h01); end
            SZ_H:    begin trimmed = {{(XLEN-16){1'b0}}, data[15:0]}; base_be = NBYTE'(8'h03); end
            SZ_W:    begin trimmed = {{(XLEN-32){1'b0}}, data[31:0]}; base_be = NBYTE'(8'h0F); end
            default: begin trimmed = data;                             base_be = {NBYTE{1'b1}}; end
        endcase
        wdata = trimmed << {lane, 3'b000};
        be    = base_be << lane;
    end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0]  rdata,
    input  logic [LANEW-1:0] lane,
    input  acc_size_e        size,
    input  logic             sign_ext,
    output logic [XLEN-1:0]  value
);
    logic [XLEN-1:0] shifted;

    always_comb begin
        shifted = rdata >> {lane, 3'b000};
        case (size)
            SZ_B:    value = {{(XLEN-8){1'b0}},  shifted[7:0]};
            SZ_H:    value = {{(XLEN-16){1'b0}}, shifted[15:0]};
            SZ_W:    value = {{(XLEN-32){sign_ext & shifted[31]}}, shifted[31:0]};
            default: value = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_resv.sv
module lsu_resv
    import lsu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set,
    input  logic                  clr,
    input  logic [XLEN-1:0]       addr,
    output logic                  hit
);
    logic                    valid_q;
    logic [XLEN-LANEW-1:0]   tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (set) begin
            valid_q <= 1'b1;
            tag_q   <= addr[XLEN-1:LANEW];
        end else if (clr) begin
            valid_q <= 1'b0;
        end
    end

    assign hit = valid_q && (tag_q == addr[XLEN-1:LANEW]);
endmodule

// File: rtl/lsu_front.sv
module lsu_front
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [4:0]        op_code,
    input  logic [63:0]       base_val,
    input  logic [15:0]       disp_val,
    input  logic [4:0]        reg_sel,
    input  logic [63:0]       src_val,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [63:0]       req_addr,
    output logic [1:0]        req_size,
    output logic              req_write,
    output logic [63:0]       req_wdata,
    output logic [7:0]        req_be,
    input  logic              rsp_valid,
    input  logic [63:0]       rsp_rdata,
    output logic              wb_valid,
    output logic [4:0]        wb_reg,
    output logic [63:0]       wb_data,
    output logic              trap,
    output logic [63:0]       trap_addr,
    output logic              op_done
);
    seq_e              state_q;
    op_dec_t           dec;
    logic [XLEN-1:0]   ea, acc_addr, st_src, st_wdata, ld_value;
    acc_size_e         acc_size;
    logic              misaligned, resv_hit, accept, suppress, wr_ok;
    logic [NBYTE-1:0]  st_be;
    logic [XLEN-1:0]   r_addr, r_wdata;
    logic [NBYTE-1:0]  r_be;
    acc_size_e         r_size;
    logic              r_write, r_cond, r_sext;
    logic [REGW-1:0]   r_reg;
    logic              resv_set, resv_clr;

    assign dec      = decode_op(op_code);
    assign accept   = op_valid && (state_q == ST_IDLE);
    assign wr_ok    = (reg_sel != ZERO_REG);
    assign suppress = !dec.addr_only && !dec.is_write && !dec.is_lock && !wr_ok;
    assign st_src   = wr_ok ? src_val : '0;

    lsu_agen u_agen (
        .dec(dec), .base(base_val), .disp(disp_val),
        .ea(ea), .acc_addr(acc_addr), .acc_size(acc_size), .misaligned(misaligned)
    );

    lsu_store_fmt u_sfmt (
        .data(st_src), .lane(acc_addr[LANEW-1:0]), .size(acc_size),
        .wdata(st_wdata), .be(st_be)
    );

    lsu_load_fmt u_lfmt (
        .rdata(rsp_rdata), .lane(r_addr[LANEW-1:0]), .size(r_size),
        .sign_ext(r_sext), .value(ld_value)
    );

    // Reservation control: a trapping or skipped operation leaves it untouched.
    assign resv_set = accept && !dec.addr_only && dec.is_lock && !misaligned;
    assign resv_clr = accept && !dec.addr_only && dec.is_cond && !misaligned;

    lsu_resv u_resv (
        .clk(clk), .rst(rst), .set(resv_set), .clr(resv_clr),
        .addr(acc_addr), .hit(resv_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            wb_valid  <= 1'b0;
            wb_reg    <= '0;
            wb_data   <= '0;
            trap      <= 1'b0;
            trap_addr <= '0;
            op_done   <= 1'b0;
            r_addr    <= '0;
            r_wdata   <= '0;
            r_be      <= '0;
            r_size    <= SZ_B;
            r_write   <= 1'b0;
            r_cond    <= 1'b0;
            r_sext    <= 1'b0;
            r_reg     <= '0;
        end else begin
            wb_valid <= 1'b0;
            trap     <= 1'b0;
            op_done  <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    wb_reg <= reg_sel;
                    if (dec.addr_only) begin
                        wb_valid <= wr_ok;
                        wb_data  <= ea;
                        op_done  <= 1'b1;
                    end else if (suppress) begin
                        op_done  <= 1'b1;
                    end else if (misaligned) begin
                        trap      <= 1'b1;
                        trap_addr <= ea;
                        op_done   <= 1'b1;
                    end else if (dec.is_cond && !resv_hit) begin
                        wb_valid <= wr_ok;
                        wb_data  <= '0;
                        op_done  <= 1'b1;
                    end else begin
                        state_q <= ST_REQ;
                        r_addr  <= acc_addr;
                        r_size  <= acc_size;
                        r_write <= dec.is_write;
                        r_cond  <= dec.is_cond;
                        r_sext  <= dec.sign_ext;
                        r_wdata <= st_wdata;
                        r_be    <= st_be;
                        r_reg   <= reg_sel;
                    end
                end
                ST_REQ: if (req_ready) begin
                    if (r_write) begin
                        state_q  <= ST_IDLE;
                        op_done  <= 1'b1;
                        wb_valid <= r_cond && (r_reg != ZERO_REG);
                        wb_reg   <= r_reg;
                        wb_data  <= XLEN'(1);
                    end else begin
                        state_q <= ST_RSP;
                    end
                end
                ST_RSP: if (rsp_valid) begin
                    state_q  <= ST_IDLE;
                    op_done  <= 1'b1;
                    wb_valid <= (r_reg != ZERO_REG);
                    wb_reg   <= r_reg;
                    wb_data  <= ld_value;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign op_ready  = (state_q == ST_IDLE);
    assign req_valid = (state_q == ST_REQ);
    assign req_addr  = r_addr;
    assign req_size  = r_size;
    assign req_write = r_write;
    assign req_wdata = r_wdata;
    assign req_be    = r_be;
endmodule

// File: rtl/lsu_front_chk.sv
module lsu_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_ready,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic [1:0]  req_size,
    input logic        req_write,
    input logic [63:0] req_wdata,
    input logic [7:0]  req_be,
    input logic        wb_valid,
    input logic [4:0]  wb_reg,
    input logic        trap,
    input logic        op_done
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                                    && $stable(req_be) && $stable(req_write) && $stable(req_size));

    // R8
    trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> !wb_valid && !req_valid);

    // R6
    no_zero_wb_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_reg != 5'd31);

    // R4
    be_width_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones(req_be) == (1 << req_size));

    // R7
    addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[2:0] & 3'((1 << req_size) - 1)) == 3'd0);

    // R12
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !op_ready);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        op_done |-> op_ready);
endmodule

bind lsu_front lsu_front_chk u_chk (.*);

// File: tb/sim_lsu_front.sv
module sim_lsu_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, op_ready;
    logic [4:0]  op_code = '0;
    logic [63:0] base_val = '0;
    logic [15:0] disp_val = '0;
    logic [4:0]  reg_sel = '0;
    logic [63:0] src_val = '0;
    logic        req_valid, req_ready = 1'b1, req_write;
    logic [63:0] req_addr, req_wdata;
    logic [1:0]  req_size;
    logic [7:0]  req_be;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_rdata = '0;
    logic        wb_valid, trap, op_done;
    logic [4:0]  wb_reg;
    logic [63:0] wb_data, trap_addr;

    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    lsu_front u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // captured outcome of one operation
    logic        got_req, got_wb, got_trap, got_done, g_write;
    logic [63:0] g_addr, g_wdata, g_wbdata, g_trap, rsp_word;
    logic [7:0]  g_be;
    logic [1:0]  g_size;
    logic [4:0]  g_wbreg;

    task automatic issue(input logic [4:0] op, input logic [63:0] b, input logic [15:0] d,
                         input logic [4:0] r, input logic [63:0] s);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; base_val = b; disp_val = d; reg_sel = r; src_val = s;
    endtask

    task automatic collect();
        logic pend;
        pend = 1'b0;
        got_req = 0; got_wb = 0; got_trap = 0; got_done = 0;
        for (int k = 0; k < 40 && !got_done; k++) begin
            @(negedge clk);
            op_valid = 1'b0; rsp_valid = 1'b0;
            if (pend) begin rsp_valid = 1'b1; rsp_rdata = rsp_word; pend = 1'b0; end
            if (wb_valid) begin got_wb = 1; g_wbreg = wb_reg; g_wbdata = wb_data; end
            if (trap) begin got_trap = 1; g_trap = trap_addr; end
            if (op_done) got_done = 1;
            if (req_valid && req_ready) begin
                got_req = 1; g_addr = req_addr; g_wdata = req_wdata; g_be = req_be;
                g_size = req_size; g_write = req_write;
                if (!req_write) pend = 1'b1;
            end
        end
        chk(got_done, "R12 op_done seen", 64'(got_done), 64'd1);
    endtask

    task automatic run(input logic [4:0] op, input logic [63:0] b, input logic [15:0] d,
                       input logic [4:0] r, input logic [63:0] s, input logic [63:0] rsp);
        rsp_word = rsp;
        issue(op, b, d, r, s);
        collect();
    endtask

    typedef struct packed {
        logic [4:0]  op;
        logic [63:0] base;
        logic [15:0] disp;
        logic [4:0]  rg;
        logic [63:0] rsp;
        logic        mem;
        logic [63:0] addr;
        logic [63:0] wb;
    } vec_t;

    localparam logic [63:0] PAT = 64'hF7E6D5C4B3A29180;
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{5'd0, 64'h100,   16'hFFF0, 5'd3, 64'h0, 1'b0, 64'h0,    64'hF0},
        '{5'd1, 64'h12345, 16'hFFFF, 5'd4, 64'h0, 1'b0, 64'h0,    64'h2345},
        '{5'd2, 64'h1000,  16'h0005, 5'd5, PAT,   1'b1, 64'h1005, 64'hD5},
        '{5'd3, 64'h1000,  16'h0006, 5'd5, PAT,   1'b1, 64'h1006, 64'hF7E6},
        '{5'd4, 64'h1000,  16'h0004, 5'd6, PAT,   1'b1, 64'h1004, 64'hFFFFFFFFF7E6D5C4},
        '{5'd4, 64'h1000,  16'h0000, 5'd6, 64'h12345678, 1'b1, 64'h1000, 64'h12345678},
        '{5'd5, 64'h1000,  16'h0008, 5'd7, PAT,   1'b1, 64'h1008, PAT},
        '{5'd6, 64'h1000,  16'h000D, 5'd7, PAT,   1'b1, 64'h1008, PAT},
        '{5'd2, 64'h1010,  16'hFFFF, 5'd8, PAT,   1'b1, 64'h100F, 64'hF7}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R12)
        chk(op_ready && !req_valid && !wb_valid && !trap && !op_done, "R12 reset state",
            {59'd0, op_ready, req_valid, wb_valid, trap, op_done}, 64'h10);

        // table walk: R1 address, R2 address ops, R3 load extension, R7 unaligned load
        for (int i = 0; i < NV; i++) begin
            run(VEC[i].op, VEC[i].base, VEC[i].disp, VEC[i].rg, 64'h0, VEC[i].rsp);
            chk(got_req == VEC[i].mem, "R2 request presence", 64'(got_req), 64'(VEC[i].mem));
            if (VEC[i].mem) chk(g_addr == VEC[i].addr, "R1/R7 req_addr", g_addr, VEC[i].addr);
            chk(got_wb && g_wbdata == VEC[i].wb && g_wbreg == VEC[i].rg, "R3 writeback", g_wbdata, VEC[i].wb);
        end

        // R4 stores: lanes and byte enables
        run(5'd9, 64'h2000, 16'h0003, 5'd5, 64'h12AB, 0);
        chk(got_req && g_write && g_be == 8'h08 && g_size == 2'd0, "R4 byte be", 64'(g_be), 64'h08);
        chk(g_wdata == 64'hAB000000 && g_addr == 64'h2003, "R4 byte data", g_wdata, 64'hAB000000);
        run(5'd10, 64'h2000, 16'h0002, 5'd5, 64'hBEEF, 0);
        chk(g_be == 8'h0C && g_wdata == 64'hBEEF0000, "R4 half lane", g_wdata, 64'hBEEF0000);
        run(5'd13, 64'h2000, 16'h000B, 5'd5, 64'h1122334455667788, 0);
        chk(!got_trap && g_addr == 64'h2008 && g_be == 8'hFF, "R7 unaligned store", g_addr, 64'h2008);
        // R10 register 31 as store source
        run(5'd12, 64'h2000, 16'h0000, 5'd31, 64'hFFFF, 0);
        chk(got_req && g_wdata == 64'h0, "R10 zero data", g_wdata, 64'h0);

        // R11 stall: request held while not ready
        req_ready = 1'b0;
        issue(5'd11, 64'h2000, 16'h0004, 5'd5, 64'hDEADBEEF);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            op_valid = 1'b0;
            chk(req_valid && req_addr == 64'h2004 && req_be == 8'hF0 && req_wdata == 64'hDEADBEEF00000000,
                "R11 held request", req_wdata, 64'hDEADBEEF00000000);
            chk(!op_ready, "R12 busy while pending", 64'(op_ready), 64'h0);
        end
        req_ready = 1'b1;
        collect();

        // R8 misaligned traps
        run(5'd4, 64'h1000, 16'h0002, 5'd6, 64'h0, PAT);
        chk(got_trap && !got_req && !got_wb && g_trap == 64'h1002, "R8 load trap", g_trap, 64'h1002);
        run(5'd10, 64'h2000, 16'h0001, 5'd6, 64'h55, 0);
        chk(got_trap && !got_req && g_trap == 64'h2001, "R8 store trap", g_trap, 64'h2001);

        // R5 loads to register 31 skipped, even misaligned
        run(5'd5, 64'h1000, 16'h0003, 5'd31, 64'h0, PAT);
        chk(!got_req && !got_trap && !got_wb, "R5 skipped misaligned", 64'(got_req | got_trap), 64'h0);
        run(5'd2, 64'h1000, 16'h0000, 5'd31, 64'h0, PAT);
        chk(!got_req && !got_wb, "R5 skipped byte", 64'(got_req), 64'h0);

        // R6 / R9 reservation
        run(5'd8, 64'h3000, 16'h0000, 5'd31, 64'h0, PAT);
        chk(got_req && !got_wb && g_addr == 64'h3000, "R6 locked load to r31", 64'(got_req), 64'h1);
        run(5'd15, 64'h3000, 16'h0000, 5'd7, 64'h55, 0);
        chk(got_req && g_wdata == 64'h55 && got_wb && g_wbreg == 5'd7 && g_wbdata == 64'h1,
            "R9 conditional success", g_wbdata, 64'h1);
        run(5'd15, 64'h3000, 16'h0000, 5'd7, 64'h55, 0);
        chk(!got_req && got_wb && g_wbdata == 64'h0, "R9 cleared after use", g_wbdata, 64'h0);
        run(5'd7, 64'h3000, 16'h0004, 5'd8, 64'h0, 64'h8000000100000000);
        chk(got_wb && g_wbdata == 64'hFFFFFFFF80000001, "R3 locked word sign", g_wbdata, 64'hFFFFFFFF80000001);
        run(5'd14, 64'h3000, 16'h0008, 5'd9, 64'h1, 0);
        chk(!got_req && got_wb && g_wbdata == 64'h0, "R9 other quadword fails", g_wbdata, 64'h0);
        run(5'd14, 64'h3000, 16'h0004, 5'd9, 64'h1, 0);
        chk(!got_req && got_wb && g_wbdata == 64'h0, "R9 cleared by failed try", g_wbdata, 64'h0);
        run(5'd7, 64'h3000, 16'h0000, 5'd8, 64'h0, 64'h0);
        run(5'd14, 64'h3000, 16'h0004, 5'd9, 64'hCAFE, 0);
        chk(got_req && g_be == 8'hF0 && g_wdata == 64'h0000CAFE00000000 && g_wbdata == 64'h1,
            "R9 same quadword success", g_wdata, 64'h0000CAFE00000000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R12 watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule